// File: doc/BRIEF.md
# Serial Register-Access Controller

This block is the digital serial front end of a converter. A host reaches four internal registers (control, setup, test and the 16-bit conversion result) over a clock line, a data-in line, a data-out line with an output enable, and an optional active-low select. Each access has two phases. The host first writes a control byte, which names the target register and the direction. The transfer to or from that register follows. The block then expects a new control byte.

The block also decides when each new conversion word lands in its result register. An internal update timer samples the word offered by the filter once per period. A data-ready line tells the host when a fresh, unread word is waiting. Before each update the line goes high for a fixed blanking window, which tells the host not to start a read. If a read has already begun when the update falls due, the load is held back until that read ends, so a word is never replaced while it is being shifted out. All serial inputs are synchronised into the master clock domain and their edges are detected there.

Top module: `ssi_regif`

## Requirements
- R1: After reset the first byte shifted in is always treated as a control byte. Control byte layout: bit 7 is the guard bit; bits 6:5 select the target (00 control, 01 setup, 10 test, 11 result); bit 4 is 1 for a read; bit 3 is standby; bit 2 is unused; bits 1:0 are gain.
- R2: A control byte with bit 7 set is discarded. The control fields stay unchanged, and the next byte is again taken as a control byte.
- R3: Setup and test are 8-bit read/write registers, shifted MSB first. After one transfer to or from either register, the next byte is a control byte.
- R4: Reading the control register returns {data_ready_n, target, read, standby, 0, gain}. The standby and gain fields drive the standby and gain outputs.
- R5: The result register is read as 16 bits, MSB first. A 16-bit write aimed at it is clocked in and discarded.
- R6: Input bits are captured on a rising serial-clock edge. The output bit changes only after a falling edge and is held across rising edges.
- R7: While select is high, the output enable is low and the bit counter is cleared, so a partial frame is dropped.
- R8: drdy_n falls when a new word is loaded into the result register. It rises when a full 16-bit result read completes. The same word can be read again.
- R9: With no read in between, drdy_n rises exactly BLANK master-clock cycles before the next update and falls at that update.
- R10: An update that falls due after the first bit of a result read is held until that read ends. The read returns the old word, and a later read returns the new one.
- R11: When a held-back update is applied in the same cycle that a result read completes, the load wins and drdy_n stays low.
- R12: While standby is set the update timer is frozen. No word is sampled and drdy_n does not change.
- R13: Reset state: drdy_n high, output enable low, setup = SETUP_RST, test = 0, gain = 0, standby = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host, idle high |
| cs_n | input | 1 | Active-low select; may be tied low |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for dout |
| drdy_n | output | 1 | Active-low data-ready |
| word_in | input | DATA_W | Conversion word offered by the filter |
| word_take | output | 1 | Pulse in the cycle word_in is sampled |
| setup_q | output | REG_W | Setup register contents |
| test_q | output | REG_W | Test register contents |
| gain | output | 2 | Gain field of the control register |
| standby | output | 1 | Standby field of the control register |

## Verification
A scheduled result update and the completion of a result read can fall in the same master-clock cycle. This happens whenever a held-back update is released by the read that blocked it. The bench provokes it by starting a result read partway into the blanking window, so that the timer's update falls due while the word is being shifted out. The bench then checks that the read returned the old word, that drdy_n is low right after the read, and that a second read returns the newly sampled word.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

   typedef enum logic [1:0] {
      TGT_CTRL  = 2'b00,
      TGT_SETUP = 2'b01,
      TGT_TEST  = 2'b10,
      TGT_DATA  = 2'b11
   } tgt_e;

   typedef enum logic {
      PH_CMD = 1'b0,
      PH_OP  = 1'b1
   } phase_e;

   typedef struct packed {
      tgt_e       tgt;
      logic       rd;
      logic       stby;
      logic [1:0] gain;
   } ctl_t;

   function automatic ctl_t ctl_decode(input logic [7:0] b);
      ctl_t c;
      c.tgt  = tgt_e'(b[6:5]);
      c.rd   = b[4];
      c.stby = b[3];
      c.gain = b[1:0];
      return c;
   endfunction

   function automatic logic [7:0] ctl_encode(input ctl_t c, input logic rdy_n);
      return {rdy_n, c.tgt, c.rd, c.stby, 1'b0, c.gain};
   endfunction

endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
   parameter int TXW = 16,
   parameter int RXW = 8,
   localparam int CW = $clog2(TXW + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           rise,
   input  logic           fall,
   input  logic           din,
   input  logic [CW-1:0]  len,
   input  logic [TXW-1:0] load_val,
   output logic           dout,
   output logic           first_fall,
   output logic           done,
   output logic [RXW-1:0] rx
);

   logic [CW-1:0]  cnt;
   logic [TXW-1:0] tx;
   logic           last_bit;

   assign last_bit   = (cnt == len - 1'b1);
   assign first_fall = fall & (cnt == '0);
   assign dout       = tx[TXW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= rise & last_bit;
         if (rise) cnt <= last_bit ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rx <= '0;
      else if (rise) rx <= {rx[RXW-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tx <= '0;
      else if (fall) tx <= (cnt == '0) ? load_val : {tx[TXW-2:0], 1'b0};
   end

endmodule

// File: rtl/ssi_upd_timer.sv
module ssi_upd_timer #(
   parameter int PERIOD = 2048,
   parameter int BLANK  = 500,
   localparam int TW = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic wrap,
   output logic blank
);

   localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (hold)   cnt <= '0;
      else if (wrap)   cnt <= '0;
      else             cnt <= cnt + 1'b1;
   end

   assign wrap = ~hold & (cnt == LAST);

   if (BLANK == 0) begin : g_noblank
      assign blank = 1'b0;
   end else begin : g_blank
      localparam logic [TW-1:0] BSTART = TW'(PERIOD - 1 - BLANK);
      assign blank = ~hold & (cnt == BSTART);
   end

endmodule

// File: rtl/ssi_regif.sv
module ssi_regif
   import ssi_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          REG_W       = 8,
   parameter int          SYNC_STAGES = 2,
   parameter int          PERIOD      = 2048,
   parameter int          BLANK       = 500,
   parameter logic [7:0]  SETUP_RST   = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              din,
   output logic              dout,
   output logic              dout_oe,
   output logic              drdy_n,
   input  logic [DATA_W-1:0] word_in,
   output logic              word_take,
   output logic [REG_W-1:0]  setup_q,
   output logic [REG_W-1:0]  test_q,
   output logic [1:0]        gain,
   output logic              standby
);

   localparam int CW  = $clog2(DATA_W + 1);
   localparam int PAD = DATA_W - REG_W;

   if (REG_W != 8) begin : g_bad_regw
      $error("ssi_regif: control layout needs REG_W of 8");
   end
   if (DATA_W <= REG_W) begin : g_bad_dataw
      $error("ssi_regif: DATA_W must exceed REG_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ssi_regif: SYNC_STAGES must be at least 2");
   end
   if (PERIOD < 4 || BLANK >= PERIOD - 1) begin : g_bad_timer
      $error("ssi_regif: BLANK must be below PERIOD-1");
   end

   // input synchronisation and edge detection
   logic [2:0] sync_o;
   logic       sclk_s, cs_s, din_s, sclk_q;
   logic       rise, fall;

   ssi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk, cs_n, din}),
      .q     (sync_o)
   );

   assign {sclk_s, cs_s, din_s} = sync_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b1;
      else        sclk_q <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_q & ~cs_s;
   assign fall = ~sclk_s & sclk_q & ~cs_s;

   // access state
   phase_e            phase;
   ctl_t              ctl;
   logic              is_data_op, is_rd_data;
   logic [CW-1:0]     len;
   logic [DATA_W-1:0] load_val;
   logic              first_fall, done;
   logic [REG_W-1:0]  rx;
   logic [DATA_W-1:0] data_q;

   assign is_data_op = (phase == PH_OP) && (ctl.tgt == TGT_DATA);
   assign is_rd_data = is_data_op && ctl.rd;
   assign len        = is_data_op ? CW'(DATA_W) : CW'(REG_W);

   always_comb begin
      case (ctl.tgt)
         TGT_CTRL:  load_val = {ctl_encode(ctl, drdy_n), {PAD{1'b0}}};
         TGT_SETUP: load_val = {setup_q, {PAD{1'b0}}};
         TGT_TEST:  load_val = {test_q, {PAD{1'b0}}};
         default:   load_val = data_q;
      endcase
   end

   ssi_shifter #(.TXW(DATA_W), .RXW(REG_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (cs_s),
      .rise       (rise),
      .fall       (fall),
      .din        (din_s),
      .len        (len),
      .load_val   (load_val),
      .dout       (dout),
      .first_fall (first_fall),
      .done       (done),
      .rx         (rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_CMD;
         ctl     <= '{tgt: TGT_CTRL, rd: 1'b0, stby: 1'b0, gain: 2'b00};
         setup_q <= SETUP_RST;
         test_q  <= '0;
      end else if (done) begin
         if (phase == PH_CMD) begin
            if (!rx[7]) begin
               ctl <= ctl_decode(rx);
               if (rx[4] || (rx[6:5] != TGT_CTRL)) phase <= PH_OP;
            end
         end else begin
            phase <= PH_CMD;
            if (!ctl.rd) begin
               case (ctl.tgt)
                  TGT_SETUP: setup_q <= rx;
                  TGT_TEST:  test_q  <= rx;
                  default:   ;
               endcase
            end
         end
      end
   end

   // update scheduling
   logic              wrap, blank;
   logic              rd_busy, rd_start, rd_done;
   logic              pend, upd_go;
   logic [DATA_W-1:0] pend_word;

   ssi_upd_timer #(.PERIOD(PERIOD), .BLANK(BLANK)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (ctl.stby),
      .wrap  (wrap),
      .blank (blank)
   );

   assign rd_start = first_fall & is_rd_data;
   assign rd_done  = done & is_rd_data;
   assign upd_go   = (wrap | pend) & ~rd_start & ~(rd_busy & ~rd_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_busy <= 1'b0;
      else if (cs_s)     rd_busy <= 1'b0;
      else if (rd_done)  rd_busy <= 1'b0;
      else if (rd_start) rd_busy <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_word <= '0;
         data_q    <= '0;
      end else begin
         if (wrap) pend_word <= word_in;
         if (upd_go) begin
            pend   <= 1'b0;
            data_q <= wrap ? word_in : pend_word;
         end else if (wrap) begin
            pend   <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                drdy_n <= 1'b1;
      else if (upd_go)           drdy_n <= 1'b0;
      else if (rd_done || blank) drdy_n <= 1'b1;
   end

   assign dout_oe   = ~cs_s;
   assign word_take = wrap;
   assign gain      = ctl.gain;
   assign standby   = ctl.stby;

endmodule

// File: rtl/ssi_regif_chk.sv
module ssi_regif_chk
   import ssi_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_s,
   input logic              fall,
   input logic              dout,
   input logic              done,
   input phase_e            phase,
   input ctl_t              ctl,
   input logic [REG_W-1:0]  rx,
   input logic [REG_W-1:0]  setup_q,
   input logic              rd_busy,
   input logic              rd_done,
   input logic              upd_go,
   input logic [DATA_W-1:0] data_q,
   input logic              drdy_n,
   input logic              blank,
   input logic              wrap
);

   AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall && !cs_s) |=> $stable(dout)); // R6

   AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (done && phase == PH_CMD && rx[7]) |=> (phase == PH_CMD && $stable(ctl))); // R2

   AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && phase == PH_OP && !ctl.rd && ctl.tgt == TGT_SETUP) |=> $stable(setup_q)); // R3

   AST_HOLD_MID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_busy && !rd_done) |=> $stable(data_q)); // R10

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && rd_done) |=> !drdy_n); // R11

   AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (blank && !upd_go) |=> drdy_n); // R9

   AST_STBY_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.stby |-> !wrap); // R12

   AST_DRDY_FALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n) |-> $past(upd_go)); // R8

endmodule

bind ssi_regif ssi_regif_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_s    (cs_s),
   .fall    (fall),
   .dout    (dout),
   .done    (done),
   .phase   (phase),
   .ctl     (ctl),
   .rx      (rx),
   .setup_q (setup_q),
   .rd_busy (rd_busy),
   .rd_done (rd_done),
   .upd_go  (upd_go),
   .data_q  (data_q),
   .drdy_n  (drdy_n),
   .blank   (blank),
   .wrap    (wrap)
);

// File: tb/ssi_regif_tb.sv
module ssi_regif_tb;

   localparam int H      = 8;
   localparam int BLANK  = 500;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b1;
   logic        cs_n = 1'b1;
   logic        din = 1'b0;
   logic        dout, dout_oe, drdy_n, word_take, standby;
   logic [15:0] word_in = 16'h1234;
   logic [7:0]  setup_q, test_q;
   logic [1:0]  gain;

   int n_run  = 0;
   int n_fail = 0;

   logic [15:0] taken = 16'h0000;
   logic        bump  = 1'b0;
   int          wt_count = 0;

   always #10 clk = ~clk;

   ssi_regif u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .din       (din),
      .dout      (dout),
      .dout_oe   (dout_oe),
      .drdy_n    (drdy_n),
      .word_in   (word_in),
      .word_take (word_take),
      .setup_q   (setup_q),
      .test_q    (test_q),
      .gain      (gain),
      .standby   (standby)
   );

   // filter model: remember each sampled word, offer a new one afterwards
   always @(negedge clk) begin
      if (bump) begin
         word_in <= word_in + 16'h0111;
         bump    <= 1'b0;
      end
      if (word_take) begin
         taken    <= word_in;
         bump     <= 1'b1;
         wt_count <= wt_count + 1;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] cmd(input logic [1:0] tgt, input logic rd,
                                      input logic stby, input logic [1:0] g);
      return {1'b0, tgt, rd, stby, 1'b0, g};
   endfunction

   task automatic xfer(input int n, input logic [15:0] w, input bit chk_edge,
                       output logic [15:0] r);
      logic a;
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b0;
         din  = w[i];
         wait_clk(H);
         a = dout;
         r = {r[14:0], a};
         sclk = 1'b1;
         wait_clk(H);
         if (chk_edge) check("R6", "dout held over rising edge", dout, a);
      end
   endtask

   task automatic wait_drdy_fall();
      while (drdy_n !== 1'b1) @(negedge clk);
      while (drdy_n !== 1'b0) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R13", "drdy_n after reset", drdy_n, 1'b1);
      check("R13", "dout_oe after reset", dout_oe, 1'b0);
      check("R13", "setup after reset", setup_q, 8'h14);
      check("R13", "test after reset", test_q, 8'h00);
      check("R13", "gain/standby after reset", {gain, standby}, 3'b000);
   endtask

   task automatic t_setup();
      logic [15:0] r;
      cs_n = 1'b0;
      wait_clk(6);
      // R1: first byte after reset is a control byte selecting setup write
      xfer(8, {8'h00, cmd(2'b01, 1'b0, 1'b0, 2'b00)}, 1'b0, r);
      xfer(8, 16'h00A5, 1'b0, r);
      wait_clk(4);
      check("R1", "setup written through control byte", setup_q, 8'hA5);
      xfer(8, {8'h00, cmd(2'b01, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(8, 16'h0000, 1'b1, r);
      check("R3", "setup read back", r[7:0], 8'hA5);
   endtask

   task automatic t_guard();
      logic [15:0] r;
      xfer(8, 16'h00A0, 1'b0, r);
      xfer(8, {8'h00, cmd(2'b01, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      wait_clk(4);
      check("R2", "setup after guarded byte", setup_q, 8'hA5);
      xfer(8, 16'h0000, 1'b0, r);
      check("R2", "next byte taken as control, setup read", r[7:0], 8'hA5);
   endtask

   task automatic t_test_reg();
      logic [15:0] r;
      xfer(8, {8'h00, cmd(2'b10, 1'b0, 1'b0, 2'b00)}, 1'b0, r);
      xfer(8, 16'h005A, 1'b0, r);
      wait_clk(4);
      check("R3", "test register written", test_q, 8'h5A);
      xfer(8, {8'h00, cmd(2'b10, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(8, 16'h0000, 1'b0, r);
      check("R3", "test register read back", r[7:0], 8'h5A);
   endtask

   task automatic t_cs();
      logic [15:0] r;
      cs_n = 1'b1;
      wait_clk(6);
      check("R7", "dout_oe with select high", dout_oe, 1'b0);
      cs_n = 1'b0;
      wait_clk(6);
      check("R7", "dout_oe with select low", dout_oe, 1'b1);
      xfer(4, 16'h000F, 1'b0, r);
      cs_n = 1'b1;
      wait_clk(6);
      cs_n = 1'b0;
      wait_clk(6);
      xfer(8, {8'h00, cmd(2'b01, 1'b0, 1'b0, 2'b00)}, 1'b0, r);
      xfer(8, 16'h0033, 1'b0, r);
      wait_clk(4);
      check("R7", "partial frame dropped, setup written", setup_q, 8'h33);
   endtask

   task automatic t_ctrl();
      logic [15:0] r;
      int          wt0;
      logic        d0;
      wait_drdy_fall();
      xfer(8, {8'h00, cmd(2'b00, 1'b0, 1'b1, 2'b11)}, 1'b0, r);
      wait_clk(4);
      check("R4", "standby and gain outputs", {standby, gain}, 3'b111);
      wt0 = wt_count;
      d0  = drdy_n;
      wait_clk(2500);
      check("R12", "no word sampled in standby", wt_count - wt0, 0);
      check("R12", "drdy_n unchanged in standby", drdy_n, d0);
      xfer(8, {8'h00, cmd(2'b00, 1'b1, 1'b1, 2'b10)}, 1'b0, r);
      xfer(8, 16'h0000, 1'b0, r);
      check("R4", "control read back", r[7:0], {d0, 7'b0011010});
      xfer(8, {8'h00, cmd(2'b00, 1'b0, 1'b0, 2'b00)}, 1'b0, r);
      wait_clk(4);
      check("R4", "standby cleared", {standby, gain}, 3'b000);
   endtask

   task automatic t_data();
      logic [15:0] r, exp;
      wait_drdy_fall();
      exp = taken;
      xfer(8, {8'h00, cmd(2'b11, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'h0000, 1'b0, r);
      check("R5", "result read", r, exp);
      check("R8", "drdy_n high after full read", drdy_n, 1'b1);
      xfer(8, {8'h00, cmd(2'b11, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'h0000, 1'b0, r);
      check("R8", "same word read again", r, exp);
   endtask

   task automatic t_data_write();
      logic [15:0] r, exp;
      wait_drdy_fall();
      exp = taken;
      xfer(8, {8'h00, cmd(2'b11, 1'b0, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'hFFFF, 1'b0, r);
      xfer(8, {8'h00, cmd(2'b11, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'h0000, 1'b0, r);
      check("R5", "result unchanged by write", r, exp);
      check("R8", "drdy_n untouched by write, high after read", drdy_n, 1'b1);
   endtask

   task automatic t_blank();
      int n;
      wait_drdy_fall();
      while (drdy_n !== 1'b1) @(negedge clk);
      n = 1;
      forever begin
         @(negedge clk);
         if (drdy_n !== 1'b1) break;
         n++;
      end
      check("R9", "blanking length in cycles", n, BLANK);
   endtask

   task automatic t_defer();
      logic [15:0] r, old;
      wait_drdy_fall();
      old = taken;
      while (drdy_n !== 1'b1) @(negedge clk);
      wait_clk(300);
      xfer(8, {8'h00, cmd(2'b11, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'h0000, 1'b0, r);
      check("R10", "read spanning update returns old word", r, old);
      check("R11", "drdy_n low after held update meets read end", drdy_n, 1'b0);
      check("R10", "new word sampled during read", taken != old, 1'b1);
      xfer(8, {8'h00, cmd(2'b11, 1'b1, 1'b0, 2'b00)}, 1'b0, r);
      xfer(16, 16'h0000, 1'b0, r);
      check("R10", "next read returns new word", r, taken);
      check("R8", "drdy_n high after reading new word", drdy_n, 1'b1);
   endtask

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_setup();
      t_guard();
      t_test_reg();
      t_cs();
      t_ctrl();
      t_data();
      t_data_write();
      t_blank();
      t_defer();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule